// File: doc/BRIEF.md
# Capture/Reload Timer

A sixteen-bit timer/counter that a byte-wide register bus controls through a single control byte. In timer operation it advances once for every cycle in which a prescaler tick input is high. In counter operation it advances on each falling edge of an external count pin. On passing through all-ones it either wraps to zero or reloads from a shared capture/reload register. A falling edge on an external trigger pin can also copy the running count into that register, or force an early reload.

The same block can supply baud clocks to a serial port. Each direction, transmit and receive, takes either this timer's overflow pulse or an overflow pulse from a neighbouring timer, which arrives as an input. While either direction uses this timer, the block forces reload-on-overflow, raises no overflow flag and ignores the trigger pin. An interrupt request combines the overflow flag and the trigger flag. A mode input masks the trigger flag's contribution when the neighbouring logic runs in up/down counting.

Register map: address 0 is the control byte, addresses 1 and 2 are the count low and high bytes, and addresses 3 and 4 are the capture/reload low and high bytes. The control byte is laid out, from bit 7 down to bit 0: overflow flag, trigger flag, receive-baud select, transmit-baud select, trigger enable, run, source select, capture select.

Top module: `capreload_timer`

## Requirements
- R1: After reset every register (addresses 0 to 4) reads 0x00 and irq_o is low.
- R2: A write to address 0 sets the control byte, including both flag bits. Writes to addresses 1/2 set the count low/high byte and writes to addresses 3/4 set the capture/reload low/high byte. Reads on reg_rdata_o return the current value, combinationally from reg_addr_i.
- R3: With run (bit 2) = 1 and source select (bit 1) = 0, the count rises by one on every clock edge that sees tick_i high. With run = 0 the count holds.
- R4: With source select = 1, tick_i is ignored and the count rises once per falling edge of cnt_pin_i. The pin passes through a two-stage synchronizer before edge detection.
- R5: A count step taken from 0xFFFF sets the overflow flag (bit 7). The flag stays set until software writes the control byte. The count wraps to 0x0000 when capture select (bit 0) = 1 and reloads from the capture/reload register when it is 0.
- R6: With trigger enable (bit 3) = 1 and capture select = 1, a falling edge on trig_pin_i copies the count into the capture/reload register and sets the trigger flag (bit 6). The count itself is unchanged.
- R7: With trigger enable = 1 and capture select = 0, a falling edge on trig_pin_i loads the count from the capture/reload register and sets the trigger flag.
- R8: With trigger enable = 0, trigger edges change neither the count, the capture/reload register nor the trigger flag.
- R9: While receive-baud (bit 5) or transmit-baud (bit 4) is 1, overflow never sets the overflow flag and always reloads, whatever capture select says, and trigger edges are ignored.
- R10: tx_baud_o carries this timer's one-cycle overflow pulse when transmit-baud = 1, and other_ovf_i when it is 0. rx_baud_o does the same under receive-baud. The pulse is high in the cycle after the clock edge at which the count overflowed.
- R11: irq_o is high when the overflow flag is set, or when the trigger flag is set and updown_mode_i is low.
- R12: A software write to the control byte in the same cycle as a hardware flag set wins: the written value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Prescaler clock enable for timer operation |
| cnt_pin_i | input | 1 | External count pin (asynchronous) |
| trig_pin_i | input | 1 | External trigger pin (asynchronous) |
| other_ovf_i | input | 1 | Overflow pulse of the neighbouring timer |
| updown_mode_i | input | 1 | Masks the trigger flag from the interrupt |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| irq_o | output | 1 | Interrupt request |
| tx_baud_o | output | 1 | Transmit baud pulse |
| rx_baud_o | output | 1 | Receive baud pulse |

## Verification
The bench sweeps start values just below, across and far from 0xFFFF with both capture-select settings. It compares the count and the overflow flag against an arithmetic step model. A design that wrapped instead of reloading, or reloaded one step late, shows a wrong count. Trigger edges are applied in every relevant combination of trigger enable, capture select and baud mode. A block that let the trigger through in baud mode, or while disabled, corrupts the capture/reload register or raises the trigger flag. The bench also checks the exact cycle of the baud pulse, the interrupt mask, and the same-cycle collision between a control write and an overflow, where a block that let hardware win would leave the overflow flag set.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Control byte; field order sets the bit positions, MSB first.
    typedef struct packed {
        logic tf;      // bit 7 overflow flag
        logic exf;     // bit 6 trigger flag
        logic rclk;    // bit 5 receive baud from this timer
        logic tclk;    // bit 4 transmit baud from this timer
        logic exen;    // bit 3 trigger enable
        logic run;     // bit 2 run
        logic ct_sel;  // bit 1 count external pin edges
        logic cp_sel;  // bit 0 capture on trigger (else reload)
    } tmr_ctrl_t;

    localparam int unsigned CTRL_ADDR = 0;

endpackage

// File: rtl/tmr_fall_detect.sv
module tmr_fall_detect #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic fall_o
);

    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } fd_state_t;

    fd_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], pin_i};
        st_d.prev = st_q.sync[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign fall_o = st_q.prev & ~st_q.sync[STAGES-1];

endmodule

// File: rtl/tmr_ctrl_reg.sv
module tmr_ctrl_reg
    import tmr_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      wr_i,
    input  logic [7:0] wdata_i,
    input  logic      ovf_i,
    input  logic      ext_evt_i,
    output tmr_ctrl_t ctrl_o,
    output logic      baud_o
);

    tmr_ctrl_t ctrl_d, ctrl_q;

    assign baud_o = ctrl_q.rclk | ctrl_q.tclk;

    always_comb begin
        ctrl_d = ctrl_q;
        if (ovf_i && !baud_o) begin
            ctrl_d.tf = 1'b1;
        end
        if (ext_evt_i) begin
            ctrl_d.exf = 1'b1;
        end
        // Software write overrides any flag set in the same cycle.
        if (wr_i) begin
            ctrl_d = tmr_ctrl_t'(wdata_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ctrl_o = ctrl_q;

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
    parameter int unsigned CNT_W = 16,
    localparam int unsigned NB   = CNT_W / 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cnt_en_i,
    input  logic             ovf_reload_i,
    input  logic             trig_cap_i,
    input  logic             trig_rld_i,
    input  logic [NB-1:0]    cnt_we_i,
    input  logic [NB-1:0]    rld_we_i,
    input  logic [7:0]       wdata_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] rld_o,
    output logic             ovf_o,
    output logic             ovf_pulse_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rld;
        logic             pulse;
    } core_state_t;

    core_state_t st_d, st_q;
    logic        ovf;

    assign ovf = cnt_en_i & (&st_q.cnt);

    always_comb begin
        st_d       = st_q;
        st_d.pulse = ovf;
        if (cnt_en_i) begin
            if (ovf) begin
                st_d.cnt = ovf_reload_i ? st_q.rld : '0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
        if (trig_rld_i) begin
            st_d.cnt = st_q.rld;
        end
        if (trig_cap_i) begin
            st_d.rld = st_q.cnt;
        end
        for (int b = 0; b < NB; b++) begin
            if (cnt_we_i[b]) begin
                st_d.cnt[b*8 +: 8] = wdata_i;
            end
            if (rld_we_i[b]) begin
                st_d.rld[b*8 +: 8] = wdata_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o     = st_q.cnt;
    assign rld_o       = st_q.rld;
    assign ovf_o       = ovf;
    assign ovf_pulse_o = st_q.pulse;

endmodule

// File: rtl/capreload_timer.sv
module capreload_timer
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned ADDR_W      = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              cnt_pin_i,
    input  logic              trig_pin_i,
    input  logic              other_ovf_i,
    input  logic              updown_mode_i,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [7:0]        reg_wdata_i,
    output logic [7:0]        reg_rdata_o,
    output logic              irq_o,
    output logic              tx_baud_o,
    output logic              rx_baud_o
);

    localparam int unsigned NB = CNT_W / 8;

    tmr_ctrl_t        ctrl;
    logic             baud;
    logic             cnt_fall;
    logic             trig_fall;
    logic             ctrl_we;
    logic [NB-1:0]    cnt_we;
    logic [NB-1:0]    rld_we;
    logic             count_en;
    logic             trig_ok;
    logic             ovf;
    logic             ovf_pulse;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] rld;

    tmr_fall_detect #(.STAGES(SYNC_STAGES)) u_cnt_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (cnt_pin_i),
        .fall_o (cnt_fall)
    );

    tmr_fall_detect #(.STAGES(SYNC_STAGES)) u_trig_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (trig_pin_i),
        .fall_o (trig_fall)
    );

    // Register decode
    assign ctrl_we = reg_we_i && (reg_addr_i == ADDR_W'(CTRL_ADDR));

    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign cnt_we[g] = reg_we_i && (reg_addr_i == ADDR_W'(1 + g));
        assign rld_we[g] = reg_we_i && (reg_addr_i == ADDR_W'(1 + NB + g));
    end

    // Count source and trigger qualification
    assign count_en = ctrl.run & (ctrl.ct_sel ? cnt_fall : tick_i);
    assign trig_ok  = ctrl.exen & ~baud & trig_fall;

    tmr_count_core #(.CNT_W(CNT_W)) u_core (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .cnt_en_i     (count_en),
        .ovf_reload_i (baud | ~ctrl.cp_sel),
        .trig_cap_i   (trig_ok & ctrl.cp_sel),
        .trig_rld_i   (trig_ok & ~ctrl.cp_sel),
        .cnt_we_i     (cnt_we),
        .rld_we_i     (rld_we),
        .wdata_i      (reg_wdata_i),
        .count_o      (count),
        .rld_o        (rld),
        .ovf_o        (ovf),
        .ovf_pulse_o  (ovf_pulse)
    );

    tmr_ctrl_reg u_ctrl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_i      (ctrl_we),
        .wdata_i   (reg_wdata_i),
        .ovf_i     (ovf),
        .ext_evt_i (trig_ok),
        .ctrl_o    (ctrl),
        .baud_o    (baud)
    );

    // Read mux
    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == ADDR_W'(CTRL_ADDR)) begin
            reg_rdata_o = ctrl;
        end
        for (int b = 0; b < NB; b++) begin
            if (reg_addr_i == ADDR_W'(1 + b)) begin
                reg_rdata_o = count[b*8 +: 8];
            end
            if (reg_addr_i == ADDR_W'(1 + NB + b)) begin
                reg_rdata_o = rld[b*8 +: 8];
            end
        end
    end

    assign irq_o     = ctrl.tf | (ctrl.exf & ~updown_mode_i);
    assign tx_baud_o = ctrl.tclk ? ovf_pulse : other_ovf_i;
    assign rx_baud_o = ctrl.rclk ? ovf_pulse : other_ovf_i;

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned ADDR_W = 3
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              reg_we_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic              updown_mode_i,
    input logic              irq_o,
    input logic              tx_baud_o,
    input logic              rx_baud_o,
    input logic              trig_fall,
    input logic [7:0]        ctrl_bits,
    input logic [CNT_W-1:0]  count,
    input logic              ovf_pulse
);

    localparam int unsigned NB = CNT_W / 8;

    logic ctrl_wr;
    logic cnt_wr;

    assign ctrl_wr = reg_we_i && (reg_addr_i == '0);
    assign cnt_wr  = reg_we_i && (reg_addr_i >= ADDR_W'(1)) && (reg_addr_i <= ADDR_W'(NB));

    AST_TF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctrl_bits[7] && !ctrl_wr |=> ctrl_bits[7]); // R5

    AST_RUN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ctrl_bits[2] && !cnt_wr && !(trig_fall && ctrl_bits[3]) |=> $stable(count)); // R3

    AST_BAUD_NO_TF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_bits[5] || ctrl_bits[4]) && !ctrl_bits[7] && !ctrl_wr |=> !ctrl_bits[7]); // R9

    AST_TRIG_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ctrl_bits[3] && !ctrl_bits[6] && !ctrl_wr |=> !ctrl_bits[6]); // R8

    AST_TX_OWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctrl_bits[4] && !ovf_pulse |-> !tx_baud_o); // R10

    AST_RX_OWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctrl_bits[5] && !ovf_pulse |-> !rx_baud_o); // R10

    AST_IRQ_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        updown_mode_i && !ctrl_bits[7] |-> !irq_o); // R11

endmodule

bind capreload_timer tmr_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_tmr_checker (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .reg_we_i      (reg_we_i),
    .reg_addr_i    (reg_addr_i),
    .updown_mode_i (updown_mode_i),
    .irq_o         (irq_o),
    .tx_baud_o     (tx_baud_o),
    .rx_baud_o     (rx_baud_o),
    .trig_fall     (trig_fall),
    .ctrl_bits     (ctrl),
    .count         (count),
    .ovf_pulse     (ovf_pulse)
);

// File: tb/test_capreload_timer.sv
`timescale 1ns/1ps
module test_capreload_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       cnt_pin = 1'b1;
    logic       trig_pin = 1'b1;
    logic       other_ovf = 1'b0;
    logic       updown = 1'b0;
    logic       we = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;
    logic       tx_baud;
    logic       rx_baud;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    capreload_timer i_capreload_timer (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .tick_i        (tick),
        .cnt_pin_i     (cnt_pin),
        .trig_pin_i    (trig_pin),
        .other_ovf_i   (other_ovf),
        .updown_mode_i (updown),
        .reg_we_i      (we),
        .reg_addr_i    (addr),
        .reg_wdata_i   (wdata),
        .reg_rdata_o   (rdata),
        .irq_o         (irq),
        .tx_baud_o     (tx_baud),
        .rx_baud_o     (rx_baud)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic rd16(input logic [2:0] a, output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(a, lo);
        rd(a + 3'd1, hi);
        v = {hi, lo};
    endtask

    task automatic set16(input logic [2:0] a, input logic [15:0] v);
        wr(a, v[7:0]);
        wr(a + 3'd1, v[15:8]);
    endtask

    task automatic tick_n(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic trig_edge();
        @(negedge clk);
        trig_pin = 1'b0;
        repeat (4) @(negedge clk);
        trig_pin = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [15:0] step(logic [15:0] c, logic [15:0] r, bit wrap0);
        return (c == 16'hFFFF) ? (wrap0 ? 16'h0000 : r) : c + 16'd1;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] v;
        logic [15:0] starts [3];
        starts[0] = 16'h0000; starts[1] = 16'h7FFE; starts[2] = 16'hFFF9;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), b);
            chk("R1 reset read", b, 8'h00);
        end
        chk("R1 irq after reset", irq, 1'b0);

        // R2 register write/read
        wr(0, 8'h0A);
        rd(0, b); chk("R2 ctrl readback", b, 8'h0A);
        set16(3'd1, 16'hBEEF);
        rd16(3'd1, v); chk("R2 count readback", v, 16'hBEEF);
        set16(3'd3, 16'h1357);
        rd16(3'd3, v); chk("R2 reload readback", v, 16'h1357);
        wr(0, 8'h00);

        // R3 / R5 sweep: start value x capture select x tick count
        foreach (starts[s]) begin
            for (int cp = 0; cp < 2; cp++) begin
                for (int n = 1; n <= 10; n++) begin
                    logic [15:0] exp_c;
                    bit          exp_tf;
                    wr(0, 8'h04 | 8'(cp));
                    set16(3'd3, 16'hABCD);
                    set16(3'd1, starts[s]);
                    tick_n(n);
                    exp_c = starts[s];
                    exp_tf = 1'b0;
                    for (int k = 0; k < n; k++) begin
                        if (exp_c == 16'hFFFF) exp_tf = 1'b1;
                        exp_c = step(exp_c, 16'hABCD, cp == 1);
                    end
                    rd16(3'd1, v); chk("R3/R5 count after ticks", v, exp_c);
                    rd(0, b); chk("R5 overflow flag", b[7], exp_tf);
                    chk("R11 irq follows overflow flag", irq, exp_tf);
                end
            end
        end

        // R3 run = 0 holds the count
        wr(0, 8'h00);
        set16(3'd1, 16'h4444);
        tick_n(20);
        rd16(3'd1, v); chk("R3 hold with run clear", v, 16'h4444);

        // R5 software clear of sticky flag
        wr(0, 8'h04);
        set16(3'd1, 16'hFFFF);
        tick_n(1);
        repeat (3) @(negedge clk);
        rd(0, b); chk("R5 flag sticky", b, 8'h84);
        wr(0, 8'h04);
        rd(0, b); chk("R5 flag cleared by write", b, 8'h04);
        chk("R11 irq low after clear", irq, 1'b0);

        // R4 counter mode: ticks ignored, pin falls counted
        wr(0, 8'h00);
        set16(3'd1, 16'h0000);
        wr(0, 8'h06);
        @(negedge clk); tick = 1'b1;
        repeat (10) @(negedge clk);
        rd16(3'd1, v); chk("R4 ticks ignored in pin mode", v, 16'h0000);
        for (int p = 0; p < 7; p++) begin
            @(negedge clk); cnt_pin = 1'b0;
            repeat (3) @(negedge clk);
            cnt_pin = 1'b1;
            repeat (3) @(negedge clk);
        end
        tick = 1'b0;
        repeat (4) @(negedge clk);
        rd16(3'd1, v); chk("R4 pin edge count", v, 16'd7);

        // R6 capture on trigger
        wr(0, 8'h09);
        set16(3'd1, 16'h5A3C);
        set16(3'd3, 16'h0000);
        trig_edge();
        rd16(3'd3, v); chk("R6 captured value", v, 16'h5A3C);
        rd16(3'd1, v); chk("R6 count unchanged", v, 16'h5A3C);
        rd(0, b); chk("R6 trigger flag set", b, 8'h49);
        chk("R11 irq from trigger flag", irq, 1'b1);
        @(negedge clk); updown = 1'b1;
        #1 chk("R11 trigger flag masked in up/down", irq, 1'b0);
        @(negedge clk); updown = 1'b0;

        // R7 reload on trigger
        wr(0, 8'h08);
        set16(3'd3, 16'h1357);
        set16(3'd1, 16'h0042);
        trig_edge();
        rd16(3'd1, v); chk("R7 count reloaded", v, 16'h1357);
        rd(0, b); chk("R7 trigger flag set", b, 8'h48);

        // R8 trigger disabled, both capture settings
        for (int cp = 0; cp < 2; cp++) begin
            wr(0, 8'(cp));
            set16(3'd1, 16'h0777);
            set16(3'd3, 16'h2222);
            trig_edge();
            rd16(3'd1, v); chk("R8 count untouched", v, 16'h0777);
            rd16(3'd3, v); chk("R8 reload untouched", v, 16'h2222);
            rd(0, b); chk("R8 ctrl untouched", b, 8'(cp));
        end

        // R9 trigger ignored in baud mode
        wr(0, 8'h19);
        set16(3'd1, 16'h0777);
        set16(3'd3, 16'h2222);
        trig_edge();
        rd16(3'd3, v); chk("R9 trigger ignored in baud mode", v, 16'h2222);
        rd(0, b); chk("R9 no trigger flag in baud mode", b, 8'h19);

        // R9 / R10 forced reload, no flag, baud pulse timing
        wr(0, 8'h00);
        set16(3'd3, 16'h4321);
        set16(3'd1, 16'hFFFF);
        wr(0, 8'h15);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        #1;
        chk("R10 tx carries own overflow pulse", tx_baud, 1'b1);
        chk("R10 rx carries neighbour pulse", rx_baud, 1'b0);
        @(negedge clk);
        #1 chk("R10 pulse lasts one cycle", tx_baud, 1'b0);
        rd16(3'd1, v); chk("R9 forced reload despite capture select", v, 16'h4321);
        rd(0, b); chk("R9 no overflow flag in baud mode", b, 8'h15);
        @(negedge clk); other_ovf = 1'b1;
        #1;
        chk("R10 rx follows neighbour", rx_baud, 1'b1);
        chk("R10 tx ignores neighbour when own", tx_baud, 1'b0);
        wr(0, 8'h20);
        #1;
        chk("R10 tx follows neighbour", tx_baud, 1'b1);
        chk("R10 rx own, no pulse", rx_baud, 1'b0);
        @(negedge clk); other_ovf = 1'b0;

        // R12 software write beats overflow set in the same cycle
        wr(0, 8'h00);
        set16(3'd3, 16'h0010);
        set16(3'd1, 16'hFFFF);
        wr(0, 8'h04);
        @(negedge clk);
        tick = 1'b1; we = 1'b1; addr = 3'd0; wdata = 8'h04;
        @(negedge clk);
        tick = 1'b0; we = 1'b0;
        rd(0, b); chk("R12 write wins over flag set", b, 8'h04);
        rd16(3'd1, v); chk("R12 overflow still reloads", v, 16'h0010);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule